// File: doc/BRIEF.md
# Snooping Four-State Coherence Line Controller

This block keeps the coherence state of a small set of lines in a private cache that shares a snooping bus with other caches. Each line holds a tag and one of four states: invalid, shared (clean, other copies may exist), exclusive (clean, the only copy) or modified (dirty, the only copy). A processor request is looked up by the low address bits (the line index) and the remaining bits (the tag). The controller then finishes it locally or asks for the bus. At the same time it watches the transactions of other caches, answers with a shared indication, and writes back dirty data when another cache needs it.

The controller is a three-state machine. `CT_IDLE` takes a new request. It finishes a hit that needs no bus traffic in the same cycle, and otherwise moves to `CT_EVICT` (a dirty line with another tag sits in the slot) or to `CT_FETCH` (a bus read or read-exclusive is needed). `CT_EVICT` asks for a write-back of the victim. On grant it invalidates the victim and goes to `CT_FETCH`. If a snoop has already taken the victim away, it goes to `CT_FETCH` without a bus request. `CT_FETCH` asks for the fill. On grant it installs the new tag and state, signals completion and returns to `CT_IDLE`. A snoop cycle freezes the machine. The snoop is applied to the line store first, and the pending request is looked at again in the next cycle against the new state. The processor holds its request stable until `pr_done`.

The bus is a request/grant handshake. A transaction takes place in the cycle in which `bus_req` and `bus_gnt` are both high. Only one transaction is on the bus at a time, so a snoop and a grant never share a cycle. A clean read fill takes the shared state when `bus_shared_in` is high in the grant cycle, and the exclusive state otherwise. This way a later write to data that no other cache holds needs no second transaction.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first processor read to any address raises `bus_req` with `bus_cmd` = 1 (read for a copy).
- R2: A processor read that misses issues `bus_cmd` = 1. On grant the line becomes shared if `bus_shared_in` is high and exclusive otherwise, and `pr_done` pulses in the grant cycle.
- R3: A processor write to an invalid or shared line issues `bus_cmd` = 2 (read-exclusive). On grant the line becomes modified.
- R4: A write to an exclusive line, a read or write to a modified line, and a read to a shared or exclusive line complete in the cycle of the request, with `pr_done` high and `bus_req` low. A write to an exclusive line leaves it modified.
- R5: A snooped access (`snp_rdx` = 0 read, 1 read-exclusive) that hits a modified line raises `snp_flush` in that cycle. A snooped read then leaves the line shared, and a snooped read-exclusive leaves it invalid.
- R6: A snooped read-exclusive that hits a shared or exclusive line invalidates it without `snp_flush`. A snooped read that hits an exclusive line leaves it shared.
- R7: `snp_shared` is high exactly when a snooped read hits a line held shared, exclusive or modified. It stays low for a snooped read-exclusive and for a miss.
- R8: A request whose slot holds a modified line with another tag first issues `bus_cmd` = 3 (write-back) at the victim's address ({victim tag, index}) and only then the fill. A clean victim is replaced with no write-back.
- R9: A snoop that arrives while a request is pending is applied first, and the request is re-evaluated against the new state. For example, a victim that was flushed and invalidated by the snoop is no longer written back. No request completes in a cycle with `snp_valid` high.
- R10: `bus_req` is low in any cycle with `snp_valid` high, `bus_cmd` is 0 whenever `bus_req` is low, and `pr_done` pulses once per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pr_valid | input | 1 | Processor request present, held until pr_done |
| pr_write | input | 1 | 1 = write, 0 = read |
| pr_addr | input | ADDR_W | {tag, index} of the request |
| pr_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus requested |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 write-back |
| bus_addr | output | ADDR_W | Address of the requested transaction |
| bus_gnt | input | 1 | Grant, transaction happens in this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (valid during a granted read) |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_rdx | input | 1 | Snooped kind: 0 read, 1 read-exclusive |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line on a read |
| snp_flush | output | 1 | This cache supplies dirty data for the snooped line |

## Verification
The bench builds the block with two lines and a two-bit tag. That makes eight addresses, and every index is shared by four tags. Random requests therefore hit dirty and clean victims often, and random snoops often land on the line that a pending request is waiting on. This reaches the write-back-then-fill path, a victim taken away by a snoop during the wait, and a shared line invalidated under a pending write. Random grant delays keep requests waiting for many cycles, so snoops keep arriving in the middle of them.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2,
        LN_MOD = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE  = 2'd0,
        BC_READ  = 2'd1,
        BC_READX = 2'd2,
        BC_WBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CT_IDLE  = 2'd0,
        CT_EVICT = 2'd1,
        CT_FETCH = 2'd2
    } ctl_st_e;

    // state left behind by a snooped transaction that hits the line
    function automatic line_st_e snoop_next(input line_st_e cur, input logic is_rdx);
        line_st_e r;
        if (cur == LN_INV || is_rdx) r = LN_INV;
        else                         r = LN_SHR;
        return r;
    endfunction

    // state installed by a granted fill
    function automatic line_st_e fill_state(input logic is_wr, input logic others_hold);
        line_st_e r;
        if (is_wr)            r = LN_MOD;
        else if (others_hold) r = LN_SHR;
        else                  r = LN_EXC;
        return r;
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TAG_W = 6,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    // lookup for the processor side
    input  logic [IDX_W-1:0] lk_idx,
    output logic [TAG_W-1:0] lk_tag,
    output line_st_e         lk_st,
    // snoop side
    input  logic             sn_valid,
    input  logic             sn_rdx,
    input  logic [IDX_W-1:0] sn_idx,
    input  logic [TAG_W-1:0] sn_tag,
    output logic             sn_hit,
    output line_st_e         sn_st,
    // update from the request machine
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  line_st_e         wr_st
);

    line_st_e         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    assign lk_tag = tag_q[lk_idx];
    assign lk_st  = st_q[lk_idx];
    assign sn_st  = st_q[sn_idx];
    assign sn_hit = (st_q[sn_idx] != LN_INV) && (tag_q[sn_idx] == sn_tag);

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                st_q[i]  <= LN_INV;
                tag_q[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                st_q[i]  <= wr_st;
                tag_q[i] <= wr_tag;
            end else if (sn_valid && sn_hit && sn_idx == IDX_W'(i)) begin
                st_q[i]  <= snoop_next(st_q[i], sn_rdx);
            end
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line_chk
        // R5: snooped read on a dirty line leaves a shared copy
        p_snoop_rd_m_to_s_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sn_valid && !sn_rdx && sn_hit && sn_idx == IDX_W'(g) && st_q[g] == LN_MOD
             && !(wr_en && wr_idx == IDX_W'(g)))
            |=> st_q[g] == LN_SHR);
        // R6: snooped read-exclusive removes any copy
        p_snoop_rdx_to_i_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (sn_valid && sn_rdx && sn_hit && sn_idx == IDX_W'(g)
             && !(wr_en && wr_idx == IDX_W'(g)))
            |=> st_q[g] == LN_INV);
    end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TAG_W = 6,
    localparam int IDX_W  = $clog2(LINES),
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pr_valid,
    input  logic              pr_write,
    input  logic [IDX_W-1:0]  pr_idx,
    input  logic [TAG_W-1:0]  pr_tag,
    input  logic [TAG_W-1:0]  lk_tag,
    input  line_st_e          lk_st,
    input  logic              snp_valid,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    output logic              pr_done,
    output logic              bus_req,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output line_st_e          wr_st
);

    ctl_st_e cur_q, nxt;

    logic     hit, victim_dirty, need_bus;
    line_st_e eff_st;

    assign hit          = (lk_st != LN_INV) && (lk_tag == pr_tag);
    assign eff_st       = hit ? lk_st : LN_INV;
    assign victim_dirty = !hit && (lk_st == LN_MOD);
    assign need_bus     = (eff_st == LN_INV) || (pr_write && eff_st == LN_SHR);
    assign wr_idx       = pr_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= CT_IDLE;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt      = cur_q;
        pr_done  = 1'b0;
        bus_req  = 1'b0;
        bus_cmd  = BC_NONE;
        bus_addr = '0;
        wr_en    = 1'b0;
        wr_tag   = pr_tag;
        wr_st    = LN_INV;
        unique case (cur_q)
            CT_IDLE: begin
                if (pr_valid && !snp_valid) begin
                    if (victim_dirty) begin
                        nxt = CT_EVICT;
                    end else if (need_bus) begin
                        nxt = CT_FETCH;
                    end else begin
                        pr_done = 1'b1;
                        wr_en   = 1'b1;
                        wr_st   = pr_write ? LN_MOD : eff_st;
                    end
                end
            end
            CT_EVICT: begin
                if (!snp_valid) begin
                    if (victim_dirty) begin
                        bus_req  = 1'b1;
                        bus_cmd  = BC_WBACK;
                        bus_addr = {lk_tag, pr_idx};
                        if (bus_gnt) begin
                            wr_en  = 1'b1;
                            wr_tag = lk_tag;
                            wr_st  = LN_INV;
                            nxt    = CT_FETCH;
                        end
                    end else begin
                        nxt = CT_FETCH;
                    end
                end
            end
            CT_FETCH: begin
                if (!snp_valid) begin
                    bus_req  = 1'b1;
                    bus_cmd  = pr_write ? BC_READX : BC_READ;
                    bus_addr = {pr_tag, pr_idx};
                    if (bus_gnt) begin
                        wr_en   = 1'b1;
                        wr_st   = fill_state(pr_write, bus_shared_in);
                        pr_done = 1'b1;
                        nxt     = CT_IDLE;
                    end
                end
            end
            default: nxt = CT_IDLE;
        endcase
    end

    // R10: no own request while another transaction is on the bus
    p_no_req_during_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !bus_req);
    // R8: a granted write-back is followed by the fill phase
    p_evict_then_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == CT_EVICT && bus_req && bus_gnt) |=> cur_q == CT_FETCH);
    // R8: write-back only issued while a dirty victim is being removed
    p_wback_only_evict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == BC_WBACK) |-> (cur_q == CT_EVICT && lk_st == LN_MOD));
    // R9: completion never shares a cycle with a snoop
    p_done_no_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pr_done |-> !snp_valid);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TAG_W = 6,
    localparam int IDX_W  = $clog2(LINES),
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pr_valid,
    input  logic              pr_write,
    input  logic [ADDR_W-1:0] pr_addr,
    output logic              pr_done,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic              snp_rdx,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush
);

    logic [IDX_W-1:0] pr_idx, sn_idx, wr_idx;
    logic [TAG_W-1:0] pr_tag, sn_tag, lk_tag, wr_tag;
    line_st_e         lk_st, sn_st, wr_st;
    logic             sn_hit, wr_en;
    bus_cmd_e         cmd_e;

    assign pr_idx = pr_addr[IDX_W-1:0];
    assign pr_tag = pr_addr[ADDR_W-1:IDX_W];
    assign sn_idx = snp_addr[IDX_W-1:0];
    assign sn_tag = snp_addr[ADDR_W-1:IDX_W];

    mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (pr_idx),
        .lk_tag   (lk_tag),
        .lk_st    (lk_st),
        .sn_valid (snp_valid),
        .sn_rdx   (snp_rdx),
        .sn_idx   (sn_idx),
        .sn_tag   (sn_tag),
        .sn_hit   (sn_hit),
        .sn_st    (sn_st),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_st    (wr_st)
    );

    mesi_req_fsm #(.LINES(LINES), .TAG_W(TAG_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pr_valid      (pr_valid),
        .pr_write      (pr_write),
        .pr_idx        (pr_idx),
        .pr_tag        (pr_tag),
        .lk_tag        (lk_tag),
        .lk_st         (lk_st),
        .snp_valid     (snp_valid),
        .bus_gnt       (bus_gnt),
        .bus_shared_in (bus_shared_in),
        .pr_done       (pr_done),
        .bus_req       (bus_req),
        .bus_cmd       (cmd_e),
        .bus_addr      (bus_addr),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_tag        (wr_tag),
        .wr_st         (wr_st)
    );

    assign bus_cmd    = cmd_e;
    assign snp_shared = snp_valid && !snp_rdx && sn_hit;
    assign snp_flush  = snp_valid && sn_hit && (sn_st == LN_MOD);

    // R7: shared answer only on a snooped read
    p_shared_reply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> (snp_valid && !snp_rdx));
    // R10: idle bus command whenever no request is raised
    p_cmd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> bus_cmd == 2'd0);

endmodule

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/100ps
module sim_mesi_line_ctrl;

    localparam int LN = 2;
    localparam int TW = 2;
    localparam int IW = 1;
    localparam int AW = TW + IW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pr_valid, pr_write, pr_done;
    logic [AW-1:0] pr_addr, bus_addr, snp_addr;
    logic          bus_req, bus_gnt, bus_shared_in;
    logic [1:0]    bus_cmd;
    logic          snp_valid, snp_rdx, snp_shared, snp_flush;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    mesi_line_ctrl #(.LINES(LN), .TAG_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .pr_valid(pr_valid), .pr_write(pr_write), .pr_addr(pr_addr), .pr_done(pr_done),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_rdx(snp_rdx), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush)
    );

    // reference model: 0 invalid, 1 shared, 2 exclusive, 3 modified
    int            m_st  [LN];
    logic [TW-1:0] m_tag [LN];
    int            m_ph;          // 0 idle, 1 evicting, 2 fetching

    // observations of the last step
    logic          o_req, o_done, o_flush, o_shared;
    int            o_cmd;
    logic [AW-1:0] o_addr;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int need_bus_f(input int eff, input bit wr);
        return (eff == 0 || (wr && eff == 1)) ? 1 : 0;
    endfunction

    task automatic step(input bit pv, input bit pw, input logic [AW-1:0] pa,
                        input bit sv, input bit sr, input logic [AW-1:0] sa,
                        input bit ag, input bit sh);
        int            idx, si, eff, e_cmd;
        logic [TW-1:0] tg, stg;
        bit            hit, vd, shit, e_req, e_done, e_sh, e_fl, g;
        logic [AW-1:0] e_addr;
        string         rtag;
        @(negedge clk);
        pr_valid = pv; pr_write = pw; pr_addr = pa;
        snp_valid = sv; snp_rdx = sr; snp_addr = sa;
        bus_shared_in = sh; bus_gnt = 1'b0;
        idx = int'(pa[IW-1:0]); tg = pa[AW-1:IW];
        si  = int'(sa[IW-1:0]); stg = sa[AW-1:IW];
        hit  = (m_st[idx] != 0) && (m_tag[idx] == tg);
        eff  = hit ? m_st[idx] : 0;
        vd   = !hit && (m_st[idx] == 3);
        shit = (m_st[si] != 0) && (m_tag[si] == stg);
        e_sh = sv && !sr && shit;
        e_fl = sv && shit && (m_st[si] == 3);
        e_req = 0; e_cmd = 0; e_addr = '0; e_done = 0;
        if (!sv) begin
            if (m_ph == 1 && vd) begin
                e_req = 1; e_cmd = 3; e_addr = {m_tag[idx], pa[IW-1:0]};
            end else if (m_ph == 2) begin
                e_req = 1; e_cmd = pw ? 2 : 1; e_addr = pa;
            end else if (m_ph == 0 && pv && !vd && need_bus_f(eff, pw) == 0) begin
                e_done = 1;
            end
        end
        #0.5;
        g = e_req && ag;
        bus_gnt = g;
        if (m_ph == 2 && g) e_done = 1;
        #0.5;
        rtag = (m_ph == 1) ? "R8" : (m_ph == 2) ? (pw ? "R3" : "R2") : "R4";
        chk(bus_req == e_req, rtag, int'(bus_req), int'(e_req));
        chk(int'(bus_cmd) == e_cmd, rtag, int'(bus_cmd), e_cmd);
        if (e_req) chk(bus_addr == e_addr, rtag, int'(bus_addr), int'(e_addr));
        chk(pr_done == e_done, "R10", int'(pr_done), int'(e_done));
        chk(snp_shared == e_sh, "R7", int'(snp_shared), int'(e_sh));
        chk(snp_flush == e_fl, "R5", int'(snp_flush), int'(e_fl));
        o_req = bus_req; o_cmd = int'(bus_cmd); o_addr = bus_addr;
        o_done = pr_done; o_flush = snp_flush; o_shared = snp_shared;
        // model update for the coming edge
        if (sv && shit) m_st[si] = (sr || m_st[si] == 0) ? 0 : 1;
        if (!sv) begin
            case (m_ph)
                0: if (pv) begin
                       if (vd) m_ph = 1;
                       else if (need_bus_f(eff, pw) != 0) m_ph = 2;
                       else begin m_tag[idx] = tg; m_st[idx] = pw ? 3 : eff; end
                   end
                1: if (vd) begin
                       if (g) begin m_st[idx] = 0; m_ph = 2; end
                   end else m_ph = 2;
                default: if (g) begin
                       m_tag[idx] = tg;
                       m_st[idx]  = pw ? 3 : (sh ? 1 : 2);
                       m_ph = 0;
                   end
            endcase
        end
    endtask

    int            dq_first_cmd;
    logic [AW-1:0] dq_first_addr;
    int            dq_cycles;

    task automatic do_req(input bit w, input logic [AW-1:0] a, input bit sh);
        dq_first_cmd = 0; dq_first_addr = '0; dq_cycles = 0;
        for (int k = 0; k < 20; k++) begin
            step(1, w, a, 0, 0, '0, 1, sh);
            dq_cycles++;
            if (o_req && dq_first_cmd == 0) begin
                dq_first_cmd = o_cmd; dq_first_addr = o_addr;
            end
            if (o_done) break;
        end
        step(0, 0, '0, 0, 0, '0, 0, 0);
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit            hv, hw, sv, sr;
        logic [AW-1:0] ha, sa;
        void'($urandom(32'd1234));
        pr_valid = 0; pr_write = 0; pr_addr = '0; bus_gnt = 0; bus_shared_in = 0;
        snp_valid = 0; snp_rdx = 0; snp_addr = '0;
        rst_n = 0;
        for (int i = 0; i < LN; i++) begin m_st[i] = 0; m_tag[i] = '0; end
        m_ph = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: after reset nothing is held
        step(0, 0, '0, 0, 0, '0, 0, 0);
        chk(!o_req && !o_done, "R1", int'(o_req), 0);
        step(1, 0, 3'd5, 0, 0, '0, 0, 0);
        step(1, 0, 3'd5, 0, 0, '0, 0, 0);
        chk(o_req && o_cmd == 1, "R1", o_cmd, 1);
        step(1, 0, 3'd5, 0, 0, '0, 1, 0);
        step(0, 0, '0, 0, 0, '0, 0, 0);

        // R2: unshared read fill gives exclusive, R4: write then local
        do_req(0, 3'd0, 0);
        chk(dq_first_cmd == 1, "R2", dq_first_cmd, 1);
        do_req(1, 3'd0, 0);
        chk(dq_cycles == 1 && dq_first_cmd == 0, "R4", dq_first_cmd, 0);
        // R5: snooped read on modified line
        step(0, 0, '0, 1, 0, 3'd0, 0, 0);
        chk(o_flush && o_shared, "R5", int'(o_flush), 1);
        // R3: write to shared line needs read-exclusive
        do_req(1, 3'd0, 0);
        chk(dq_first_cmd == 2, "R3", dq_first_cmd, 2);
        step(0, 0, '0, 1, 1, 3'd0, 0, 0);
        chk(o_flush && !o_shared, "R5", int'(o_flush), 1);
        // R2: shared fill, R7 shared answer, R3 upgrade
        do_req(0, 3'd0, 1);
        step(0, 0, '0, 1, 0, 3'd0, 0, 0);
        chk(o_shared && !o_flush, "R7", int'(o_shared), 1);
        do_req(1, 3'd0, 0);
        chk(dq_first_cmd == 2, "R3", dq_first_cmd, 2);

        // R6: read-exclusive snoop invalidates an exclusive line
        do_req(0, 3'd1, 0);
        step(0, 0, '0, 1, 1, 3'd1, 0, 0);
        chk(!o_flush && !o_shared, "R6", int'(o_flush), 0);
        do_req(0, 3'd1, 0);
        chk(dq_first_cmd == 1, "R6", dq_first_cmd, 1);
        // R6: snooped read moves exclusive to shared, write then needs the bus
        step(0, 0, '0, 1, 0, 3'd1, 0, 0);
        chk(o_shared && !o_flush, "R6", int'(o_shared), 1);
        do_req(1, 3'd1, 0);
        chk(dq_first_cmd == 2, "R6", dq_first_cmd, 2);

        // R8: dirty victim at index 0 (tag 0) written back before fill
        do_req(0, 3'd2, 0);
        chk(dq_first_cmd == 3 && dq_first_addr == 3'd0, "R8", dq_first_cmd, 3);
        do_req(0, 3'd4, 0);
        chk(dq_first_cmd == 1, "R8", dq_first_cmd, 1);

        // R9: victim flushed by a snoop while waiting for grant
        do_req(1, 3'd4, 0);
        step(1, 0, 3'd0, 0, 0, '0, 0, 0);
        step(1, 0, 3'd0, 0, 0, '0, 0, 0);
        chk(o_req && o_cmd == 3 && o_addr == 3'd4, "R9", o_cmd, 3);
        step(1, 0, 3'd0, 1, 1, 3'd4, 0, 0);
        chk(o_flush && !o_req && !o_done, "R9", int'(o_req), 0);
        step(1, 0, 3'd0, 0, 0, '0, 1, 0);
        chk(!o_req, "R9", int'(o_req), 0);
        do_req(0, 3'd0, 0);
        chk(dq_first_cmd == 1, "R9", dq_first_cmd, 1);

        // constrained random traffic against the model
        hv = 0; hw = 0; ha = '0;
        for (int n = 0; n < 4000; n++) begin
            if (!hv && ($urandom % 3) == 0) begin
                hv = 1; hw = 1'($urandom % 2); ha = AW'($urandom);
            end
            sv = (($urandom % 4) == 0);
            sr = 1'($urandom % 2);
            sa = AW'($urandom);
            step(hv, hw, ha, sv, sr, sa, 1'($urandom % 2), 1'($urandom % 2));
            if (o_done) hv = 0;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule